// File: doc/BRIEF.md
# Not-Recently-Used Victim Selector with Held Decode State

This block chooses replacement ways for a 4-way set-associative cache. Each set has one reference bit per way, and a set bit means the way was used recently. A tag lookup that hits sends an update for the way that hit. A miss first sends a decode request for the set. The block reads that set's reference bits and returns the lowest-numbered way whose bit is clear as the victim. Some cycles later the allocating encode writes the new state for the set.

The state array cannot be written in the decode cycle, and the encode step does not read it. The bits read at decode are therefore held in a register until the matching allocation encode. From the held copy the encode can tell whether the set was full. If it was, the encode writes a vector with only the new way set, which ages out all the other ways.

Only one decode can wait for its encode at a time. A decode request that arrives while one is waiting is refused, and the busy output shows the refusal.

Top module: `nru_repl_ctrl`

## Requirements
- R1: After reset, every reference bit of every set is 0. `dec_busy` is 0 and `victim_valid` is 0. A decode of any untouched set returns way 0.
- R2: A decode is accepted when `dec_valid` is high and `dec_busy` is low. In the next cycle `victim_valid` is high for one cycle, and `victim_way` is the lowest way index whose bit was 0 in that set.
- R3: If all bits of the decoded set are 1, the victim is way 0.
- R4: An allocation encode (`enc_valid`=1, `enc_hit`=0) while a decode is pending writes the whole set as the held bits OR the bit of `enc_way`. It also ends the pending state.
- R5: If the held bits were all 1, the allocation encode writes a vector with only the bit of `enc_way` set. All the other ways then read as not recently used.
- R6: A hit encode (`enc_hit`=1) sets only the bit of `enc_way` in `enc_set` and leaves the other bits unchanged. It does not change the pending state or the held bits.
- R7: While a decode is pending, `dec_busy` is 1. A decode request in that state is ignored: no `victim_valid` pulse follows and the held bits are unchanged.
- R8: An allocation encode with no decode pending acts like a hit: it sets only the bit of `enc_way`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode request |
| dec_set | input | SET_W | Set index to decode |
| dec_busy | output | 1 | A decode is pending; new decodes are refused |
| victim_valid | output | 1 | One-cycle pulse, victim ready |
| victim_way | output | WAY_W | Chosen victim way |
| enc_valid | input | 1 | Encode request |
| enc_set | input | SET_W | Set index to update |
| enc_way | input | WAY_W | Way that hit or was allocated |
| enc_hit | input | 1 | 1 = hit update, 0 = allocation |

## Verification
The bench builds the block with WAYS=4 and SETS=8. With only eight sets, a directed sequence can drive one set through every occupancy pattern: empty, partly full, full and reset back to one way. Other sets stay available for the busy-refusal and no-pending cases.

Because hits on another set can occur while a decode is pending, the interaction between held state and single-bit updates is exercised. A behavioural model, compared each cycle, tracks victim choice and busy through all of these cases.

// File: rtl/nru_pkg.sv
package nru_pkg;
  localparam int unsigned MAXW = 32;

  // Lowest index below n whose bit is clear; 0 when none is clear.
  function automatic logic [4:0] lowest_clear(input logic [MAXW-1:0] v, input int unsigned n);
    logic [4:0] r;
    r = '0;
    for (int i = MAXW - 1; i >= 0; i--) begin
      if (i < n && !v[i]) r = 5'(i);
    end
    return r;
  endfunction

  // New row after an allocation from the held row.
  function automatic logic [MAXW-1:0] alloc_row(input logic [MAXW-1:0] held,
                                                input logic [MAXW-1:0] sel,
                                                input int unsigned n);
    logic full;
    full = 1'b1;
    for (int i = 0; i < MAXW; i++) begin
      if (i < n && !held[i]) full = 1'b0;
    end
    return full ? sel : (held | sel);
  endfunction
endpackage

// File: rtl/nru_state_mem.sv
module nru_state_mem #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int SET_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAYS-1:0]  rd_bits,
  input  logic             full_we,
  input  logic [SET_W-1:0] full_set,
  input  logic [WAYS-1:0]  full_bits,
  input  logic             bit_we,
  input  logic [SET_W-1:0] bit_set,
  input  logic [WAY_W-1:0] bit_way
);
  logic [WAYS-1:0] rows [SETS];

  assign rd_bits = rows[rd_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rows[s] <= '0;
    end else if (full_we) begin
      rows[full_set] <= full_bits;
    end else if (bit_we) begin
      rows[bit_set][bit_way] <= 1'b1;
    end
  end

  // R6: a single-bit write sets that bit and leaves the others unchanged
  p_hit_sets_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && !full_we) |=> rows[$past(bit_set)][$past(bit_way)]);
  p_hit_keeps_others_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && !full_we && !$past(!rst_n)) |=>
      ((rows[$past(bit_set)] | (WAYS'(1) << $past(bit_way))) ==
       ($past(rows[bit_set]) | (WAYS'(1) << $past(bit_way)))));
endmodule

// File: rtl/nru_hold_reg.sv
module nru_hold_reg #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [WAYS-1:0]  rd_bits,
  input  logic             release_hold,
  output logic             pending,
  output logic [WAYS-1:0]  held_bits,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way
);
  import nru_pkg::*;

  logic [4:0] pick;
  assign pick = lowest_clear(MAXW'(rd_bits), WAYS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending      <= 1'b0;
      held_bits    <= '0;
      victim_valid <= 1'b0;
      victim_way   <= '0;
    end else begin
      victim_valid <= take;
      if (take) begin
        pending    <= 1'b1;
        held_bits  <= rd_bits;
        victim_way <= WAY_W'(pick);
      end else if (release_hold) begin
        pending <= 1'b0;
      end
    end
  end

  // R2: the victim's bit was clear, unless the set was full
  p_victim_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_valid && !(&held_bits)) |-> !held_bits[victim_way]);
  // R3: a full set gives way 0
  p_full_way0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_valid && (&held_bits)) |-> (victim_way == '0));
  // R7: held bits stay put while pending without a new take
  p_held_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !take) |=> $stable(held_bits));
endmodule

// File: rtl/nru_repl_ctrl.sv
module nru_repl_ctrl #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [SET_W-1:0] dec_set,
  output logic             dec_busy,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way,
  input  logic             enc_valid,
  input  logic [SET_W-1:0] enc_set,
  input  logic [WAY_W-1:0] enc_way,
  input  logic             enc_hit
);
  import nru_pkg::*;

  logic            pending;
  logic [WAYS-1:0] held_bits;
  logic [WAYS-1:0] rd_bits;
  logic [WAYS-1:0] new_row;
  logic [MAXW-1:0] row_wide;
  logic            dec_take;
  logic            alloc_fire;
  logic            single_fire;

  assign dec_busy    = pending;
  assign dec_take    = dec_valid && !pending;
  assign alloc_fire  = enc_valid && !enc_hit && pending;
  assign single_fire = enc_valid && (enc_hit || !pending);
  assign row_wide    = alloc_row(MAXW'(held_bits), MAXW'(1) << enc_way, WAYS);
  assign new_row     = row_wide[WAYS-1:0];

  nru_state_mem #(.SETS(SETS), .WAYS(WAYS)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .rd_set(dec_set), .rd_bits(rd_bits),
    .full_we(alloc_fire), .full_set(enc_set), .full_bits(new_row),
    .bit_we(single_fire), .bit_set(enc_set), .bit_way(enc_way)
  );

  nru_hold_reg #(.WAYS(WAYS)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .take(dec_take), .rd_bits(rd_bits), .release_hold(alloc_fire),
    .pending(pending), .held_bits(held_bits),
    .victim_valid(victim_valid), .victim_way(victim_way)
  );

  // R2: accepted decode gives a victim pulse next cycle
  p_victim_after_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_busy) |=> victim_valid);
  // R7: a refused decode gives no pulse
  p_busy_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_busy) |=> !victim_valid);
  // R5: a full held set is rewritten with exactly one bit
  p_reset_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && (&held_bits)) |-> ($countones(new_row) == 1));
  // R4: allocation ends the pending state
  p_alloc_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> !dec_busy);
  // R6: a hit leaves the pending state alone
  p_hit_keeps_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid && enc_hit && !dec_valid) |=> (dec_busy == $past(dec_busy)));
endmodule

// File: tb/tb_nru_repl_ctrl.sv
module tb_nru_repl_ctrl;
  localparam int SETS = 8;
  localparam int WAYS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0;
  logic [2:0] dec_set = '0;
  logic dec_busy, victim_valid;
  logic [1:0] victim_way;
  logic enc_valid = 1'b0;
  logic [2:0] enc_set = '0;
  logic [1:0] enc_way = '0;
  logic enc_hit = 1'b0;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  // behavioural model
  int m_bits [SETS];
  bit m_pend = 0;
  int m_held = 0;
  bit m_vv = 0;
  int m_vw = 0;

  always #2.5 clk = ~clk;

  nru_repl_ctrl #(.SETS(SETS), .WAYS(WAYS)) dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_set(dec_set),
    .dec_busy(dec_busy), .victim_valid(victim_valid), .victim_way(victim_way),
    .enc_valid(enc_valid), .enc_set(enc_set), .enc_way(enc_way), .enc_hit(enc_hit)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_bits[i]) m_bits[i] = 0;
      m_pend = 0; m_held = 0; m_vv = 0; m_vw = 0;
    end else begin
      automatic bit take = dec_valid && !m_pend;
      automatic int rd = m_bits[dec_set];
      automatic bit alloc = enc_valid && !enc_hit && m_pend;
      if (alloc)
        m_bits[enc_set] = (m_held == 15) ? (1 << enc_way) : (m_held | (1 << enc_way));
      else if (enc_valid)
        m_bits[enc_set] = m_bits[enc_set] | (1 << enc_way);
      m_vv = take;
      if (take) begin
        m_pend = 1; m_held = rd; m_vw = 0;
        for (int w = WAYS - 1; w >= 0; w--) if (((rd >> w) & 1) == 0) m_vw = w;
      end else if (alloc) m_pend = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, int'(dec_busy), int'(m_pend), "busy");
      check(cur_req, int'(victim_valid), int'(m_vv), "victim_valid");
      if (m_vv) check(cur_req, int'(victim_way), m_vw, "victim_way");
    end
  end

  task automatic dec(input int s, input int exp_way, input string req);
    cur_req = req;
    dec_valid = 1; dec_set = 3'(s);
    @(negedge clk);
    dec_valid = 0;
    check(req, int'(victim_valid), 1, "direct victim_valid");
    check(req, int'(victim_way), exp_way, "direct victim_way");
  endtask

  task automatic enc(input int s, input int w, input bit hit, input string req);
    cur_req = req;
    enc_valid = 1; enc_set = 3'(s); enc_way = 2'(w); enc_hit = hit;
    @(negedge clk);
    enc_valid = 0; enc_hit = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", int'(dec_busy), 0, "reset busy");
        check("R1", int'(victim_valid), 0, "reset victim_valid");
        dec(0, 0, "R1");
        enc(0, 0, 0, "R4");
        // R2 partial occupancy on set 1
        enc(1, 0, 1, "R6");
        enc(1, 1, 1, "R6");
        dec(1, 2, "R2");
        enc(1, 2, 0, "R4");
        dec(1, 3, "R4");
        enc(1, 3, 0, "R4");
        dec(1, 0, "R3");
        enc(1, 0, 0, "R5");
        dec(1, 1, "R5");
        enc(1, 1, 0, "R4");
        dec(1, 2, "R5");
        enc(1, 2, 0, "R4");
        // R7 refused decode while pending
        dec(2, 0, "R7");
        cur_req = "R7";
        check("R7", int'(dec_busy), 1, "busy while pending");
        dec_valid = 1; dec_set = 3'd3;
        @(negedge clk);
        dec_valid = 0;
        check("R7", int'(victim_valid), 0, "refused decode pulse");
        enc(3, 0, 1, "R6");
        check("R6", int'(dec_busy), 1, "busy kept after hit");
        enc(2, 0, 0, "R7");
        check("R7", int'(dec_busy), 0, "busy cleared");
        dec(3, 1, "R6");
        enc(3, 1, 0, "R4");
        // R8 allocation without pending decode
        enc(4, 0, 0, "R8");
        enc(4, 1, 0, "R8");
        dec(4, 2, "R8");
        enc(4, 3, 0, "R4");
        dec(5, 0, "R1");
        enc(5, 0, 0, "R4");
        repeat (2) @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule